// File: doc/BRIEF.md
# Colour Subcarrier Frequency Synthesizer

This block is the colour subcarrier source of a composite video encoder. It runs on the 27 MHz pixel clock. A 32-bit phase accumulator advances by a programmable step every cycle, and the upper bits of that phase drive a sine lookup. The block has two outputs. The first is a reference subcarrier sample, which the chroma modulator downstream uses. The second is a colour burst sample that is scaled by an amplitude register and forced to zero outside the burst window.

Software programs the block through a byte-wide write port. Four byte slots build the phase step, and the step is swapped in as a whole only when its top byte arrives. Two more slots hold a 16-bit hue rotation, and one slot holds the burst amplitude. A standard-select input sets the burst angle:
- In 525-line colour mode the burst is rotated half a turn from the reference axis.
- In PAL mode the burst sits at 135 degrees on one line and at 225 degrees on the next. The V-axis sign flips at every line-start strobe from the timing generator.

Top module: `chroma_subcarrier_dds`

## Requirements
- R1: While `rst` is high at a clock edge, both outputs become 0, the accumulator becomes 0, hue becomes 0, amplitude becomes 0x80 and the line-alternation flag clears. The phase step is loaded with 0x21F07C1F when `pal_mode`=0 and with 0x2A098ACB when `pal_mode`=1.
- R2: Out of reset, the accumulator adds the active phase step at every clock edge and wraps modulo 2^32. The reference output is the sine of bits 31:16 of the accumulator plus the hue word, taking bits 15:6 of that 16-bit sum as the table index.
- R3: The select values for writes are: 0 = step bits 7:0, 1 = step bits 15:8, 2 = step bits 23:16, 3 = step bits 31:24. Writes to selects 0 to 2 only stage a byte and leave the running step unchanged. A write to select 3 replaces all 32 step bits at once with that byte and the three staged bytes. A write to select 7 changes nothing.
- R4: Select 4 writes hue bits 7:0 and select 5 writes hue bits 15:8. The hue word is added, modulo 2^16, to the 16-bit phase used by both lookups.
- R5: Select 6 writes the amplitude. While `burst_gate` is high, the burst output is floor(s × amplitude / 128), where s is the table value at the burst phase.
- R6: While `burst_gate` is low, the burst output is 0.
- R7: With `pal_mode`=0, the burst phase is the reference phase plus 0x8000 (180 degrees).
- R8: With `pal_mode`=1, the burst phase is the reference phase plus 0x6000 (135 degrees) while the alternation flag is 0, and plus 0xA000 (225 degrees) while it is 1. The flag toggles at every edge where `line_start` is high. With `pal_mode`=0 the flag is cleared.
- R9: The table has 1024 points. Point k is round(511 × sin(2π(k+0.5)/1024)), rounded half away from zero. It is stored as one quarter wave and unfolded by symmetry, so its magnitude never exceeds 511.
- R10: Both outputs are registered. Each reflects the inputs and the register state present at the preceding clock edge, and a register write affects the outputs from the second edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pal_mode | input | 1 | 0 = 525-line burst angle, 1 = PAL alternating angle |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register slot select |
| reg_wdata | input | 8 | Register write byte |
| line_start | input | 1 | One-cycle strobe at each video line start |
| burst_gate | input | 1 | High during the colour burst window |
| sub_sine | output | 10 | Signed reference subcarrier sample |
| burst_out | output | 12 | Signed gated and scaled burst sample |

## Verification
Each sample appears one edge after the accumulator, hue, amplitude and alternation state it was computed from. A register write therefore shows up at the second edge after it is issued.

The bench drives inputs on the falling edge and computes the expected samples from its model before the rising edge. It samples the outputs 1 ns after that edge and only then advances its model. This order lets it confirm that staged step bytes leave the frequency untouched until the top byte is written, and that the PAL angle follows the flag held before each strobe.

// File: rtl/subcarrier_pkg.sv
package subcarrier_pkg;

    localparam int PHASE_W   = 32;
    localparam int HUE_W     = 16;
    localparam int AMP_W     = 8;
    localparam int BYTE_W    = 8;
    localparam int LUT_BITS  = 10;
    localparam int SINE_W    = 10;
    localparam int AMP_SHIFT = 7;
    localparam int SEL_W     = 3;

    localparam int INC_BYTES = PHASE_W / BYTE_W;
    localparam int STAGE_W   = PHASE_W - BYTE_W;
    localparam int QTR_BITS  = LUT_BITS - 2;
    localparam int QTR_SIZE  = 2 ** QTR_BITS;
    localparam int SINE_PEAK = 2 ** (SINE_W - 1) - 1;
    localparam int PROD_W    = SINE_W + AMP_W + 1;
    localparam int BURST_W   = PROD_W - AMP_SHIFT;

    localparam logic [PHASE_W-1:0] STEP_525 = 32'h21F0_7C1F;
    localparam logic [PHASE_W-1:0] STEP_PAL = 32'h2A09_8ACB;
    localparam logic [AMP_W-1:0]   AMP_INIT = 8'h80;

    typedef enum logic [SEL_W-1:0] {
        SLOT_STEP0  = 3'd0,
        SLOT_STEP1  = 3'd1,
        SLOT_STEP2  = 3'd2,
        SLOT_STEP3  = 3'd3,
        SLOT_HUE_LO = 3'd4,
        SLOT_HUE_HI = 3'd5,
        SLOT_AMP    = 3'd6,
        SLOT_SPARE  = 3'd7
    } slot_e;

    typedef struct packed {
        logic [PHASE_W-1:0] step;
        logic [HUE_W-1:0]   hue;
        logic [AMP_W-1:0]   amp;
    } sc_cfg_t;

    typedef logic [SINE_W-2:0] qtab_t [QTR_SIZE];

    // Quarter wave sampled at half-step offsets so the other quadrants mirror exactly.
    function automatic qtab_t build_qtab();
        qtab_t t;
        real   v;
        for (int i = 0; i < QTR_SIZE; i++) begin
            v    = real'(SINE_PEAK) * $sin(2.0 * 3.14159265358979 * (real'(i) + 0.5)
                                           / real'(4 * QTR_SIZE));
            t[i] = (SINE_W-1)'($rtoi(v + 0.5));
        end
        return t;
    endfunction

    function automatic logic [PHASE_W-1:0] reset_step(logic pal);
        return pal ? STEP_PAL : STEP_525;
    endfunction

    // Burst angle as a fraction of a turn in HUE_W bits.
    function automatic logic [HUE_W-1:0] burst_angle(logic pal, logic flip);
        logic [HUE_W-1:0] a;
        if (!pal)     a = HUE_W'(1) << (HUE_W - 1);
        else if (flip) a = HUE_W'(5) << (HUE_W - 3);
        else           a = HUE_W'(3) << (HUE_W - 3);
        return a;
    endfunction

endpackage

// File: rtl/sc_host_regs.sv
module sc_host_regs
    import subcarrier_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pal_mode,
    input  logic              reg_we,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [BYTE_W-1:0] reg_wdata,
    output sc_cfg_t           cfg
);

    logic [STAGE_W-1:0] stage_q;
    logic [PHASE_W-1:0] init_step;
    sc_cfg_t            cfg_q;

    assign init_step = reset_step(pal_mode);
    assign cfg       = cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q      <= init_step[STAGE_W-1:0];
            cfg_q.step   <= init_step;
            cfg_q.hue    <= '0;
            cfg_q.amp    <= AMP_INIT;
        end else if (reg_we) begin
            for (int b = 0; b < INC_BYTES - 1; b++) begin
                if (reg_sel == SEL_W'(b))
                    stage_q[b*BYTE_W +: BYTE_W] <= reg_wdata;
            end
            case (slot_e'(reg_sel))
                SLOT_STEP3:  cfg_q.step <= {reg_wdata, stage_q};
                SLOT_HUE_LO: cfg_q.hue[BYTE_W-1:0] <= reg_wdata;
                SLOT_HUE_HI: cfg_q.hue[HUE_W-1:BYTE_W] <= reg_wdata;
                SLOT_AMP:    cfg_q.amp <= reg_wdata;
                default: ;
            endcase
        end
    end

    AST_STEP_HELD: assert property (@(posedge clk) disable iff (rst)
        (!(reg_we && reg_sel == SLOT_STEP3)) |=> $stable(cfg_q.step)); // R3

    AST_STEP_TOP_BYTE: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_sel == SLOT_STEP3) |=>
            (cfg_q.step[PHASE_W-1 -: BYTE_W] == $past(reg_wdata))); // R3

    AST_SPARE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_sel == SLOT_SPARE) |=> ($stable(cfg_q) && $stable(stage_q))); // R3

endmodule

// File: rtl/sc_phase_acc.sv
module sc_phase_acc
    import subcarrier_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               pal_mode,
    input  logic               line_start,
    input  logic [PHASE_W-1:0] step,
    output logic [PHASE_W-1:0] phase,
    output logic               v_flip
);

    logic [PHASE_W-1:0] acc_q;
    logic               flip_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            flip_q <= 1'b0;
        end else begin
            acc_q <= acc_q + step;
            if (!pal_mode)
                flip_q <= 1'b0;
            else if (line_start)
                flip_q <= ~flip_q;
        end
    end

    assign phase  = acc_q;
    assign v_flip = flip_q;

    AST_FLIP_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (!pal_mode) |=> !v_flip); // R8

endmodule

// File: rtl/sc_sine_rom.sv
module sc_sine_rom
    import subcarrier_pkg::*;
(
    input  logic [LUT_BITS-1:0]     idx,
    output logic signed [SINE_W-1:0] val
);

    localparam qtab_t QTAB = build_qtab();

    logic [1:0]          quadrant;
    logic [QTR_BITS-1:0] offs;
    logic [QTR_BITS-1:0] addr;
    logic [SINE_W-2:0]   mag;

    always_comb begin
        quadrant = idx[LUT_BITS-1 -: 2];
        offs     = idx[QTR_BITS-1:0];
        addr     = quadrant[0] ? ~offs : offs;
        mag      = QTAB[addr];
        val      = quadrant[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    end

endmodule

// File: rtl/chroma_subcarrier_dds.sv
module chroma_subcarrier_dds
    import subcarrier_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      pal_mode,
    input  logic                      reg_we,
    input  logic [2:0]                reg_sel,
    input  logic [7:0]                reg_wdata,
    input  logic                      line_start,
    input  logic                      burst_gate,
    output logic signed [SINE_W-1:0]  sub_sine,
    output logic signed [BURST_W-1:0] burst_out
);

    localparam int N_LOOKUPS = 2;

    sc_cfg_t            cfg;
    logic [PHASE_W-1:0] phase;
    logic               v_flip;
    logic [HUE_W-1:0]   ref_phase;
    logic [HUE_W-1:0]   bst_phase;

    logic [LUT_BITS-1:0]      rom_idx [N_LOOKUPS];
    logic signed [SINE_W-1:0] rom_val [N_LOOKUPS];

    logic signed [PROD_W-1:0]  prod;
    logic signed [PROD_W-1:0]  scaled;
    logic signed [BURST_W-1:0] burst_d;
    logic signed [SINE_W-1:0]  sine_q;
    logic signed [BURST_W-1:0] burst_q;

    sc_host_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .pal_mode  (pal_mode),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .cfg       (cfg)
    );

    sc_phase_acc u_acc (
        .clk        (clk),
        .rst        (rst),
        .pal_mode   (pal_mode),
        .line_start (line_start),
        .step       (cfg.step),
        .phase      (phase),
        .v_flip     (v_flip)
    );

    always_comb begin
        ref_phase  = phase[PHASE_W-1 -: HUE_W] + cfg.hue;
        bst_phase  = ref_phase + burst_angle(pal_mode, v_flip);
        rom_idx[0] = ref_phase[HUE_W-1 -: LUT_BITS];
        rom_idx[1] = bst_phase[HUE_W-1 -: LUT_BITS];
    end

    for (genvar g = 0; g < N_LOOKUPS; g++) begin : g_lookup
        sc_sine_rom u_rom (
            .idx (rom_idx[g]),
            .val (rom_val[g])
        );
    end

    always_comb begin
        prod    = rom_val[1] * $signed({1'b0, cfg.amp});
        scaled  = prod >>> AMP_SHIFT;
        burst_d = burst_gate ? scaled[BURST_W-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sine_q  <= '0;
            burst_q <= '0;
        end else begin
            sine_q  <= rom_val[0];
            burst_q <= burst_d;
        end
    end

    assign sub_sine  = sine_q;
    assign burst_out = burst_q;

    AST_BURST_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!burst_gate) |=> (burst_out == '0)); // R6

    AST_SINE_BOUND: assert property (@(posedge clk) disable iff (rst)
        (int'(sub_sine) <= SINE_PEAK) && (int'(sub_sine) >= -SINE_PEAK)); // R9

    AST_BURST_BOUND: assert property (@(posedge clk) disable iff (rst)
        burst_gate |=>
            ((int'(burst_out) <= ((SINE_PEAK * int'($past(cfg.amp))) >>> AMP_SHIFT)) &&
             (int'(burst_out) >= -((SINE_PEAK * int'($past(cfg.amp))) >>> AMP_SHIFT) - 1))); // R5

endmodule

// File: tb/sim_chroma_subcarrier_dds.sv
`timescale 1ns/1ps
module sim_chroma_subcarrier_dds;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst, pal_mode, reg_we, line_start, burst_gate;
    logic [2:0]        reg_sel;
    logic [7:0]        reg_wdata;
    logic signed [9:0]  sub_sine;
    logic signed [11:0] burst_out;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [31:0] m_acc, m_step;
    logic [23:0] m_stage;
    logic [15:0] m_hue;
    logic [7:0]  m_amp;
    logic        m_flip;

    chroma_subcarrier_dds u0 (
        .clk        (clk),
        .rst        (rst),
        .pal_mode   (pal_mode),
        .reg_we     (reg_we),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .line_start (line_start),
        .burst_gate (burst_gate),
        .sub_sine   (sub_sine),
        .burst_out  (burst_out)
    );

    function automatic int ref_sine(int k);
        real r;
        r = 511.0 * $sin(2.0 * 3.14159265358979 * (real'(k) + 0.5) / 1024.0);
        if (r >= 0.0) return $rtoi(r + 0.5);
        return -$rtoi(-r + 0.5);
    endfunction

    function automatic logic [15:0] angle_of(bit pal, bit flip);
        if (!pal) return 16'h8000;
        return flip ? 16'hA000 : 16'h6000;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One clock: drive inputs, predict, sample after the edge, advance the model.
    task automatic cyc(bit r, bit pal, bit we, logic [2:0] sel, logic [7:0] d,
                       bit g, bit ls, string tag);
        int          es, eb;
        logic [15:0] pr, pb;
        rst = r; pal_mode = pal; reg_we = we; reg_sel = sel; reg_wdata = d;
        burst_gate = g; line_start = ls;
        if (r) begin
            es = 0; eb = 0;
        end else begin
            pr = m_acc[31:16] + m_hue;
            pb = pr + angle_of(pal, m_flip);
            es = ref_sine(int'(pr[15:6]));
            eb = g ? ((ref_sine(int'(pb[15:6])) * int'(m_amp)) >>> 7) : 0;
        end
        @(posedge clk);
        #1;
        if (r) begin
            m_acc = '0; m_hue = '0; m_amp = 8'h80; m_flip = 1'b0;
            m_step = pal ? 32'h2A098ACB : 32'h21F07C1F;
            m_stage = m_step[23:0];
        end else begin
            m_acc = m_acc + m_step;
            if (we) begin
                case (sel)
                    3'd0: m_stage[7:0]   = d;
                    3'd1: m_stage[15:8]  = d;
                    3'd2: m_stage[23:16] = d;
                    3'd3: m_step = {d, m_stage};
                    3'd4: m_hue[7:0]  = d;
                    3'd5: m_hue[15:8] = d;
                    3'd6: m_amp = d;
                    default: ;
                endcase
            end
            m_flip = pal ? (ls ? ~m_flip : m_flip) : 1'b0;
        end
        check(tag == "" ? "R2" : tag, "sub_sine", int'(sub_sine), es);
        check(tag == "" ? (g ? "R5" : "R6") : tag, "burst_out", int'(burst_out), eb);
        @(negedge clk);
    endtask

    task automatic idle(int n, bit pal, bit g, string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, pal, 1'b0, 3'd0, 8'h00, g, 1'b0, tag);
    endtask

    task automatic wr(bit pal, logic [2:0] sel, logic [7:0] d, string tag);
        cyc(1'b0, pal, 1'b1, sel, d, 1'b0, 1'b0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        m_acc = '0; m_step = '0; m_stage = '0; m_hue = '0; m_amp = '0; m_flip = 1'b0;
        rst = 1'b1; pal_mode = 1'b0; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0;
        burst_gate = 1'b0; line_start = 1'b0;
        @(negedge clk);

        // R1: reset clears outputs; first sample uses phase 0 and the 525-line step
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0, "R1");
        idle(4, 1'b0, 1'b0, "R1");
        idle(20, 1'b0, 1'b0, "R2");

        // R3: stage 0x00400000 byte by byte; frequency only changes after the top byte
        wr(1'b0, 3'd0, 8'h00, "R3");
        wr(1'b0, 3'd1, 8'h00, "R3");
        wr(1'b0, 3'd2, 8'h40, "R3");
        idle(5, 1'b0, 1'b0, "R3");
        wr(1'b0, 3'd7, 8'hFF, "R3");
        wr(1'b0, 3'd3, 8'h00, "R3");
        // R10: first edge after a write still shows the old state
        idle(2, 1'b0, 1'b0, "R10");
        // R9: one table point per clock walks every quadrant
        idle(1100, 1'b0, 1'b0, "R9");

        // R4: hue rotation by a quarter turn, then an odd value
        wr(1'b0, 3'd5, 8'h40, "R4");
        idle(40, 1'b0, 1'b0, "R4");
        wr(1'b0, 3'd4, 8'hC3, "R4");
        wr(1'b0, 3'd5, 8'h81, "R4");
        idle(40, 1'b0, 1'b0, "R4");

        // R7: 525-line burst angle with default amplitude
        idle(60, 1'b0, 1'b1, "R7");
        // R5: full and zero amplitude
        wr(1'b0, 3'd6, 8'hFF, "R5");
        idle(60, 1'b0, 1'b1, "R5");
        wr(1'b0, 3'd6, 8'h00, "R5");
        idle(10, 1'b0, 1'b1, "R5");
        wr(1'b0, 3'd6, 8'h5A, "R5");
        // R6: gate low
        idle(20, 1'b0, 1'b0, "R6");

        // R8: PAL reset, alternating burst angle across line strobes
        for (int i = 0; i < 2; i++) cyc(1'b1, 1'b1, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, "R1");
        for (int ln = 0; ln < 8; ln++) begin
            cyc(1'b0, 1'b1, 1'b0, 3'd0, 8'h00, 1'b0, 1'b1, "R8");
            idle(12, 1'b1, 1'b1, "R8");
        end
        // R8: leaving PAL clears the flag; returning restarts at 135 degrees
        idle(3, 1'b0, 1'b1, "R8");
        idle(6, 1'b1, 1'b1, "R8");

        // Random mix of writes, gates, strobes and standard changes
        for (int i = 0; i < 4000; i++) begin
            bit          we, g, ls, pal;
            logic [2:0]  sel;
            logic [7:0]  d;
            we  = ($urandom % 4) == 0;
            sel = 3'($urandom % 8);
            d   = 8'($urandom);
            g   = ($urandom % 3) != 0;
            ls  = ($urandom % 16) == 0;
            pal = (i / 700) % 2 == 1;
            cyc(($urandom % 997) == 0, pal, we, sel, d, g, ls, "");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule